// File: doc/BRIEF.md
# Parity-Checked Bidirectional Byte Transceiver

This block joins two 8-bit buses, a receive side and a transmit side, through a pair of opposite data paths. A single parity line travels with the transmit side. Two active-low enables pick one of four modes:
- **MODE_XMIT** moves receive-side data onto the transmit side and generates an odd-parity bit.
- **MODE_RECV** moves transmit-side data onto the receive side and checks the arriving data plus its parity bit.
- **MODE_ISOLATE** drives nothing.
- **MODE_FORCE** transmits deliberately wrong parity, so that the fault path can be exercised as a self-test.

Every three-state pin is split into an input, an output and an output enable. The open-drain fault pin is modelled as the level the pulled-up line shows, plus a pull-down enable.

A 9-bit XOR tree checks either the outgoing data with its generated parity (MODE_XMIT, MODE_FORCE) or the incoming data with its received parity (MODE_RECV). A two-state flag machine samples that result on the rising clock. It has the states FLAG_CLEAN and FLAG_FAULT:
- **FLAG_CLEAN → FLAG_FAULT** is taken on a sampling edge whose check finds an even count of ones.
- **FLAG_FAULT → FLAG_FAULT** is taken on every edge, so the fault stays captured.
- **FLAG_FAULT → FLAG_CLEAN** happens only when the asynchronous clear is driven low. The same clear puts the machine in FLAG_CLEAN at power-up.

In MODE_ISOLATE the machine does not sample.

Top module: `parity_xcvr`

## Requirements
- R1: With `en_t_n`=0 and `en_r_n`=1 (MODE_XMIT), `t_oe`=1, `par_oe`=1, `r_oe`=0, `t_out` equals `r_in`, and `par_out` is 0 when `r_in` holds an odd number of ones and 1 when it holds an even number.
- R2: With `en_t_n`=1 and `en_r_n`=0 (MODE_RECV), `r_oe`=1, `t_oe`=0, `par_oe`=0, and `r_out` equals `t_in`.
- R3: In MODE_RECV, a rising clock edge at which `t_in` together with `par_in` holds an even number of ones leaves `err_level`=0 after that edge.
- R4: Once `err_level` is 0 it stays 0 on every later edge, whatever the mode or data, until the clear is applied.
- R5: Driving `clr_n` low sets `err_level` to 1 at once, without a clock edge. It overrides a faulting clock edge in the same cycle, and it is the power-up state.
- R6: With both enables 1 (MODE_ISOLATE), `t_oe`, `r_oe` and `par_oe` are all 0 and `err_level` does not change on the clock edge.
- R7: With both enables 0 (MODE_FORCE), `t_oe`=1, `par_oe`=1, `r_oe`=0, `t_out` equals `r_in`, `par_out` is the inverse of the MODE_XMIT parity, and `err_level` is 0 after the first rising edge in this mode.
- R8: MODE_XMIT never sets the fault: `err_level` stays 1 through transmit edges.
- R9: `err_pull_dn` is 1 exactly when `err_level` is 0. The line is pulled down only in the fault state.
- R10: `t_oe` and `r_oe` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Flag sampling clock, rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the fault flag |
| en_t_n | input | 1 | Active-low transmit-side enable |
| en_r_n | input | 1 | Active-low receive-side enable |
| r_in | input | 8 | Receive-side bus as seen by the block |
| r_out | output | 8 | Receive-side bus drive value |
| r_oe | output | 1 | Receive-side bus drive enable |
| t_in | input | 8 | Transmit-side bus as seen by the block |
| t_out | output | 8 | Transmit-side bus drive value |
| t_oe | output | 1 | Transmit-side bus drive enable |
| par_in | input | 1 | Parity line as seen by the block |
| par_out | output | 1 | Parity line drive value |
| par_oe | output | 1 | Parity line drive enable |
| err_level | output | 1 | Fault line level with pull-up (1 = no fault) |
| err_pull_dn | output | 1 | Open-drain pull-down enable for the fault line |

## Verification
The data, parity and enable outputs are combinational, so they are due in the same cycle as the enables and data. The bench drives on the falling edge and compares one nanosecond later. The fault flag changes only on the rising edge that samples a check. The bench updates its reference flag right after that edge and compares it against `err_level` and `err_pull_dn` at the following falling edge, before new stimulus is applied. The clear is checked one nanosecond after it falls, with no edge in between, and again after a faulting edge that it must override.

// File: rtl/pxcvr_pkg.sv
package pxcvr_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_XMIT    = 2'd1,
        MODE_RECV    = 2'd2,
        MODE_FORCE   = 2'd3
    } xcvr_mode_e;

    typedef enum logic {
        FLAG_CLEAN = 1'b0,
        FLAG_FAULT = 1'b1
    } flag_state_e;
endpackage

// File: rtl/pxcvr_mode_dec.sv
module pxcvr_mode_dec
    import pxcvr_pkg::*;
(
    input  logic       en_t_n,
    input  logic       en_r_n,
    output xcvr_mode_e mode,
    output logic       t_oe,
    output logic       r_oe,
    output logic       par_oe,
    output logic       chk_local,
    output logic       flip_par,
    output logic       sample_en
);
    // Enable pair to mode
    always_comb begin
        unique case ({en_t_n, en_r_n})
            2'b01:   mode = MODE_XMIT;
            2'b10:   mode = MODE_RECV;
            2'b00:   mode = MODE_FORCE;
            default: mode = MODE_ISOLATE;
        endcase
    end

    // Mode to drive enables and checker controls
    always_comb begin
        t_oe      = 1'b0;
        r_oe      = 1'b0;
        par_oe    = 1'b0;
        chk_local = 1'b1;
        flip_par  = 1'b0;
        sample_en = 1'b1;
        unique case (mode)
            MODE_XMIT: begin
                t_oe   = 1'b1;
                par_oe = 1'b1;
            end
            MODE_RECV: begin
                r_oe      = 1'b1;
                chk_local = 1'b0;
            end
            MODE_FORCE: begin
                t_oe     = 1'b1;
                par_oe   = 1'b1;
                flip_par = 1'b1;
            end
            MODE_ISOLATE: begin
                sample_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pxcvr_xor_tree.sv
module pxcvr_xor_tree #(
    parameter int unsigned WIDTH = 9
) (
    input  logic [WIDTH-1:0] bits,
    output logic             odd
);
    logic [WIDTH:0] acc;
    assign acc[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        assign acc[g+1] = acc[g] ^ bits[g];
    end

    assign odd = acc[WIDTH];
endmodule

// File: rtl/pxcvr_err_flag.sv
module pxcvr_err_flag
    import pxcvr_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic sample_en,
    input  logic check_ok,
    output logic err_level,
    output logic err_pull_dn
);
    flag_state_e state_q, state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAN: if (sample_en && !check_ok) state_d = FLAG_FAULT;
            FLAG_FAULT: state_d = FLAG_FAULT;
        endcase
    end

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= FLAG_CLEAN;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            FLAG_CLEAN: begin
                err_level   = 1'b1;
                err_pull_dn = 1'b0;
            end
            FLAG_FAULT: begin
                err_level   = 1'b0;
                err_pull_dn = 1'b1;
            end
        endcase
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!clr_n)
        (state_q == FLAG_FAULT) |=> (state_q == FLAG_FAULT)); // R4
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
    import pxcvr_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              en_t_n,
    input  logic              en_r_n,
    input  logic [DATA_W-1:0] r_in,
    output logic [DATA_W-1:0] r_out,
    output logic              r_oe,
    input  logic [DATA_W-1:0] t_in,
    output logic [DATA_W-1:0] t_out,
    output logic              t_oe,
    input  logic              par_in,
    output logic              par_out,
    output logic              par_oe,
    output logic              err_level,
    output logic              err_pull_dn
);
    localparam int unsigned CHK_W = DATA_W + 1;

    xcvr_mode_e        mode;
    logic              chk_local, flip_par, sample_en;
    logic              r_odd, par_gen, par_tx, chk_ok;
    logic [CHK_W-1:0]  chk_bits;

    pxcvr_mode_dec u_dec (
        .en_t_n    (en_t_n),
        .en_r_n    (en_r_n),
        .mode      (mode),
        .t_oe      (t_oe),
        .r_oe      (r_oe),
        .par_oe    (par_oe),
        .chk_local (chk_local),
        .flip_par  (flip_par),
        .sample_en (sample_en)
    );

    // Generator: output is 1 when the byte holds an even count of ones
    pxcvr_xor_tree #(.WIDTH(DATA_W)) u_gen (
        .bits (r_in),
        .odd  (r_odd)
    );

    assign par_gen = ~r_odd;
    assign par_tx  = flip_par ? ~par_gen : par_gen;

    assign t_out   = r_in;
    assign r_out   = t_in;
    assign par_out = par_tx;

    // Checker: odd count across 9 bits means healthy
    assign chk_bits = chk_local ? {r_in, par_tx} : {t_in, par_in};

    pxcvr_xor_tree #(.WIDTH(CHK_W)) u_chk (
        .bits (chk_bits),
        .odd  (chk_ok)
    );

    pxcvr_err_flag u_flag (
        .clk         (clk),
        .clr_n       (clr_n),
        .sample_en   (sample_en),
        .check_ok    (chk_ok),
        .err_level   (err_level),
        .err_pull_dn (err_pull_dn)
    );

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!clr_n)
        !(t_oe && r_oe)); // R10
    AST_XMIT_PARITY_ODD: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_t_n && en_r_n) |-> (par_oe && (^{t_out, par_out}))); // R1
    AST_RECV_FAULT: assert property (@(posedge clk) disable iff (!clr_n)
        (en_t_n && !en_r_n && !(^{t_in, par_in})) |=> !err_level); // R3
    AST_ISOLATE_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (en_t_n && en_r_n) |=> $stable(err_level)); // R6
    AST_FORCE_FAULT: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_t_n && !en_r_n) |=> !err_level); // R7
endmodule

// File: tb/tb_parity_xcvr.sv
`timescale 1ns/1ps
module tb_parity_xcvr;
    logic       clk = 1'b0;
    logic       clr_n, en_t_n, en_r_n, par_in;
    logic [7:0] r_in, t_in;
    logic [7:0] r_out, t_out;
    logic       r_oe, t_oe, par_out, par_oe, err_level, err_pull_dn;

    int  checks = 0;
    int  fails  = 0;
    bit  m_flag = 1'b1;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    parity_xcvr dut (
        .clk(clk), .clr_n(clr_n), .en_t_n(en_t_n), .en_r_n(en_r_n),
        .r_in(r_in), .r_out(r_out), .r_oe(r_oe),
        .t_in(t_in), .t_out(t_out), .t_oe(t_oe),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
        .err_level(err_level), .err_pull_dn(err_pull_dn)
    );

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic flag_chk(input string tag);
        chk({tag, " err_level"}, {7'd0, err_level}, {7'd0, m_flag});
        chk("R9 err_pull_dn", {7'd0, err_pull_dn}, {7'd0, !m_flag});
    endtask

    // One cycle: check flag from the previous edge, drive, check outputs, clock, update model
    task automatic step(input logic et, input logic er, input logic [7:0] rv,
                        input logic [7:0] tv, input logic pv, input string ftag);
        bit odd_r;
        @(negedge clk);
        flag_chk(ftag);
        en_t_n = et; en_r_n = er; r_in = rv; t_in = tv; par_in = pv;
        #1;
        odd_r = (ones(rv) % 2) == 1;
        chk("R10 contention", {7'd0, t_oe && r_oe}, 8'd0);
        case ({et, er})
            2'b01: begin
                chk("R1 t_oe", {7'd0, t_oe}, 8'd1);
                chk("R1 r_oe", {7'd0, r_oe}, 8'd0);
                chk("R1 par_oe", {7'd0, par_oe}, 8'd1);
                chk("R1 t_out", t_out, rv);
                chk("R1 par_out", {7'd0, par_out}, {7'd0, !odd_r});
            end
            2'b10: begin
                chk("R2 r_oe", {7'd0, r_oe}, 8'd1);
                chk("R2 t_oe", {7'd0, t_oe}, 8'd0);
                chk("R2 par_oe", {7'd0, par_oe}, 8'd0);
                chk("R2 r_out", r_out, tv);
            end
            2'b11: begin
                chk("R6 enables", {5'd0, t_oe, r_oe, par_oe}, 8'd0);
            end
            default: begin
                chk("R7 t_oe", {7'd0, t_oe}, 8'd1);
                chk("R7 r_oe", {7'd0, r_oe}, 8'd0);
                chk("R7 par_oe", {7'd0, par_oe}, 8'd1);
                chk("R7 t_out", t_out, rv);
                chk("R7 par_out", {7'd0, par_out}, {7'd0, odd_r});
            end
        endcase
        @(posedge clk);
        case ({et, er})
            2'b10:   if (((ones(tv) + int'(pv)) % 2) == 0) m_flag = 1'b0;
            2'b00:   m_flag = 1'b0;
            default: ;
        endcase
    endtask

    task automatic do_clear();
        @(negedge clk);
        flag_chk("R4 before clear");
        en_t_n = 1'b1; en_r_n = 1'b0; t_in = 8'h03; par_in = 1'b0; // faulting receive
        clr_n = 1'b0;
        m_flag = 1'b1;
        #1;
        flag_chk("R5 immediate clear");
        @(posedge clk);
        @(negedge clk);
        flag_chk("R5 clear beats edge");
        clr_n = 1'b1;
        en_t_n = 1'b1; en_r_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clr_n = 1'b0; en_t_n = 1'b1; en_r_n = 1'b1;
        r_in = 8'h00; t_in = 8'h00; par_in = 1'b0;
        #5;
        flag_chk("R5 reset state");
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr_n = 1'b1;

        // Transmit patterns, flag must stay clean (R8)
        step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R8");
        step(1'b0, 1'b1, 8'h01, 8'hFF, 1'b0, "R8");
        step(1'b0, 1'b1, 8'hFF, 8'h00, 1'b1, "R8");
        step(1'b0, 1'b1, 8'hA5, 8'h00, 1'b0, "R8");
        step(1'b0, 1'b1, 8'h07, 8'h00, 1'b0, "R8");
        // Good receives
        step(1'b1, 1'b0, 8'h00, 8'h01, 1'b0, "R8");
        step(1'b1, 1'b0, 8'h00, 8'h03, 1'b1, "R3");
        // Isolate with clean flag and faulting data on the bus
        step(1'b1, 1'b1, 8'h00, 8'h03, 1'b0, "R3");
        step(1'b1, 1'b1, 8'h5A, 8'h00, 1'b0, "R6");
        // Bad receive
        step(1'b1, 1'b0, 8'h00, 8'h03, 1'b0, "R6");
        // Sticky through good receive, transmit, isolate
        step(1'b1, 1'b0, 8'h00, 8'h80, 1'b0, "R3");
        step(1'b0, 1'b1, 8'h3C, 8'h00, 1'b0, "R4");
        step(1'b1, 1'b1, 8'h00, 8'h00, 1'b0, "R4");
        step(1'b1, 1'b1, 8'h00, 8'h00, 1'b0, "R6");
        do_clear();
        // Forced-error self-test
        step(1'b1, 1'b1, 8'h00, 8'h00, 1'b0, "R5");
        step(1'b0, 1'b0, 8'h96, 8'h00, 1'b0, "R5");
        step(1'b0, 1'b1, 8'h00, 8'h00, 1'b0, "R7");
        do_clear();
        step(1'b0, 1'b0, 8'h01, 8'h00, 1'b0, "R5");
        do_clear();
        // Sweep receive patterns, clearing after each fault
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 1'b0, 8'h00, 8'(i * 37 + 11), 1'(i % 3 == 0), "R3");
            if (!m_flag) do_clear();
        end
        step(1'b1, 1'b1, 8'h00, 8'h00, 1'b0, "R3");
        @(negedge clk);
        flag_chk("R6 final");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule